// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block picks the handshake answer that endpoint zero returns during a control transfer. A serial interface engine passes it decoded token strobes: a SETUP arrival, an IN token, an OUT token and a flag that says whether the current token belongs to the data stage or the status stage. The engine also reports when the host acknowledged an IN data packet and when an OUT data packet was taken in. For every token the block returns a two-bit response code, registered, one clock later.

Firmware controls the endpoint through a small register bus. It can arm the IN data stage by writing an IN byte count or the low byte of a setup data pointer. It can arm the OUT data stage by writing an OUT byte count. It can release the status stage by clearing a handshake-hold bit, and it can force a stall. A SETUP token returns all of this to a known starting point: it disarms both directions, drops the stall and sets the handshake hold again. The status stage therefore stays on NAK until firmware has finished decoding the request.

Top module: `ep0_hs_resp`

## Requirements
- R1: After reset the control register (address 0) reads 0 and `rsp_valid` is low.
- R2: A SETUP token is answered with ACK (code 1). In the following cycle the IN-busy bit (control bit 2) and the stall bit (bit 0) are 0, the handshake-hold bit (bit 1) is 1, and OUT is disarmed. This holds even when a CPU write lands in the same cycle.
- R3: Writing the IN count register (address 1) sets IN-busy. A data-stage IN token returns DATA (code 0) while IN-busy is set and NAK (code 2) while it is clear.
- R4: Writing the low pointer byte (address 4) also sets IN-busy. Writing the high byte (address 3) does not arm. Both bytes read back.
- R5: Writing the OUT count register (address 2) arms OUT, and that count reads back. A data-stage OUT token returns ACK while OUT is armed and NAK while it is not.
- R6: A host acknowledge clears IN-busy. An accepted OUT packet disarms OUT.
- R7: Writing 1 to control bit 1 clears the handshake hold. Writing 0 to that bit leaves it unchanged. Writes to bit 2 have no effect.
- R8: A status-stage IN or OUT token returns NAK while the handshake hold is 1 and ACK once it is 0.
- R9: Writing 1 to control bit 0 sets the stall bit and writing 0 clears it. While it is set, every IN or OUT token returns STALL (code 3), whatever the stage, the arming or the handshake hold.
- R10: `rsp_valid` is high exactly one clock after a token strobe and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_setup | input | 1 | SETUP token strobe |
| tok_in | input | 1 | IN token strobe |
| tok_out | input | 1 | OUT token strobe |
| stat_phase | input | 1 | 1 when the token belongs to the status stage |
| host_ack | input | 1 | Host acknowledged the IN data packet |
| out_rcvd | input | 1 | OUT data packet accepted |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data (combinational) |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 2 | 0 DATA, 1 ACK, 2 NAK, 3 STALL |

## Verification
The hardest case to reach is a token that meets a particular mix of stall, handshake hold, IN arming and OUT arming, because each flag is set or cleared by a different event. The bench starts every vector with a SETUP token, which puts all four flags in a known state. It then issues at most one control-register write and the arming writes that build the wanted mix. This covers all 64 combinations of the four flags, the stage and the direction, and each response is compared with a priority model in the bench. Separate sequences check the pointer arming, the clearing events, the ignored writes and a CPU write landing in the same cycle as a SETUP token.

// File: rtl/ep0_hs_resp.sv
module ep0_hs_resp #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_setup,
  input  logic          tok_in,
  input  logic          tok_out,
  input  logic          stat_phase,
  input  logic          host_ack,
  input  logic          out_rcvd,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          rsp_valid,
  output logic [1:0]    rsp_code
);
  localparam logic [AW-1:0] A_CSR = 0, A_INCNT = 1, A_OUTCNT = 2, A_PTRH = 3, A_PTRL = 4;
  localparam logic [1:0] C_DATA = 2'd0, C_ACK = 2'd1, C_NAK = 2'd2, C_STALL = 2'd3;

  logic in_busy, hsnak, stall, out_arm;
  logic [DW-1:0] in_cnt, out_cnt, ptr_h, ptr_l;
  logic [1:0] code_nxt;

  wire wr_csr = cpu_we && cpu_addr == A_CSR;

  always_comb begin
    if (tok_setup)                code_nxt = C_ACK;
    else if (stall)               code_nxt = C_STALL;
    else if (stat_phase)          code_nxt = hsnak ? C_NAK : C_ACK;
    else if (tok_in)              code_nxt = in_busy ? C_DATA : C_NAK;
    else                          code_nxt = out_arm ? C_ACK : C_NAK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_busy <= 1'b0;
      hsnak   <= 1'b0;
      stall   <= 1'b0;
      out_arm <= 1'b0;
    end else if (tok_setup) begin
      in_busy <= 1'b0;
      hsnak   <= 1'b1;
      stall   <= 1'b0;
      out_arm <= 1'b0;
    end else begin
      if (host_ack) in_busy <= 1'b0;
      if (out_rcvd) out_arm <= 1'b0;
      if (cpu_we && (cpu_addr == A_INCNT || cpu_addr == A_PTRL)) in_busy <= 1'b1;
      if (cpu_we && cpu_addr == A_OUTCNT) out_arm <= 1'b1;
      if (wr_csr) begin
        stall <= cpu_wdata[0];
        if (cpu_wdata[1]) hsnak <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      out_cnt <= '0;
      ptr_h   <= '0;
      ptr_l   <= '0;
    end else if (cpu_we) begin
      case (cpu_addr)
        A_INCNT:  in_cnt  <= cpu_wdata;
        A_OUTCNT: out_cnt <= cpu_wdata;
        A_PTRH:   ptr_h   <= cpu_wdata;
        A_PTRL:   ptr_l   <= cpu_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= C_NAK;
    end else begin
      rsp_valid <= tok_setup | tok_in | tok_out;
      if (tok_setup | tok_in | tok_out) rsp_code <= code_nxt;
    end
  end

  always_comb begin
    case (cpu_addr)
      A_CSR:    cpu_rdata = {{(DW-3){1'b0}}, in_busy, hsnak, stall};
      A_INCNT:  cpu_rdata = in_cnt;
      A_OUTCNT: cpu_rdata = out_cnt;
      A_PTRH:   cpu_rdata = ptr_h;
      A_PTRL:   cpu_rdata = ptr_l;
      default:  cpu_rdata = '0;
    endcase
  end
endmodule

module ep0_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_setup,
  input logic       tok_in,
  input logic       tok_out,
  input logic       stat_phase,
  input logic       in_busy,
  input logic       hsnak,
  input logic       stall,
  input logic       rsp_valid,
  input logic [1:0] rsp_code
);
  wire tok_any = tok_setup | tok_in | tok_out;

  p_setup_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_setup |=> hsnak && !stall && !in_busy && rsp_code == 2'd1);

  p_stall_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in || tok_out) && !tok_setup && stall |=> rsp_valid && rsp_code == 2'd3);

  p_in_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tok_in && !tok_setup && !stat_phase && !stall && !in_busy |=> rsp_code == 2'd2);

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in || tok_out) && !tok_setup && stat_phase && !stall && hsnak |=> rsp_code == 2'd2);

  p_valid_on_tok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tok_any |=> rsp_valid);

  p_valid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_any |=> !rsp_valid);
endmodule

bind ep0_hs_resp ep0_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tok_setup(tok_setup), .tok_in(tok_in), .tok_out(tok_out),
  .stat_phase(stat_phase), .in_busy(in_busy), .hsnak(hsnak), .stall(stall),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code)
);

// File: tb/tb_ep0_hs_resp.sv
module tb_ep0_hs_resp;
  logic clk = 0, rst_n = 0;
  logic tok_setup = 0, tok_in = 0, tok_out = 0, stat_phase = 0, host_ack = 0, out_rcvd = 0;
  logic cpu_we = 0;
  logic [2:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic rsp_valid;
  logic [1:0] rsp_code;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ep0_hs_resp dut (.*);

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); cpu_we = 1; cpu_addr = a[2:0]; cpu_wdata = d[7:0];
    @(negedge clk); cpu_we = 0; cpu_addr = 0;
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    cpu_addr = a[2:0]; #1;
    chk(tag, cpu_rdata, exp);
    cpu_addr = 0;
  endtask

  // kind: 0 setup, 1 in, 2 out
  task automatic tok(input int kind, input bit ph, output int code, output bit vld);
    @(negedge clk);
    tok_setup = (kind == 0); tok_in = (kind == 1); tok_out = (kind == 2); stat_phase = ph;
    @(negedge clk);
    tok_setup = 0; tok_in = 0; tok_out = 0; stat_phase = 0;
    code = rsp_code; vld = rsp_valid;
  endtask

  task automatic pulse_ack(input bit which);
    @(negedge clk); host_ack = !which; out_rcvd = which;
    @(negedge clk); host_ack = 0; out_rcvd = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog got 0 exp 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c; bit v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd("R1 csr", 0, 0);
    chk("R1 valid", rsp_valid, 0);

    // R2 setup answer and state
    tok(0, 0, c, v);
    chk("R2 code", c, 1); chk("R10 valid", v, 1);
    rd("R2 csr", 0, 3'b010);
    @(negedge clk); chk("R10 quiet", rsp_valid, 0);

    // sweep R3 R5 R8 R9: 64 combinations
    for (int i = 0; i < 64; i++) begin
      bit st, hs, ia, oa, ph, din; int e;
      st = i[0]; hs = i[1]; ia = i[2]; oa = i[3]; ph = i[4]; din = i[5];
      tok(0, 0, c, v);
      if (ia) wr(1, i + 1);
      if (oa) wr(2, i + 2);
      wr(0, (hs ? 0 : 2) | (st ? 1 : 0));
      rd("R7 csr", 0, {ia, hs, st});
      if (st) e = 3;
      else if (ph) e = hs ? 2 : 1;
      else if (din) e = ia ? 0 : 2;
      else e = oa ? 1 : 2;
      tok(din ? 1 : 2, ph, c, v);
      chk(st ? "R9 stall" : ph ? "R8 status" : din ? "R3 in" : "R5 out", c, e);
      chk("R10 valid", v, 1);
    end

    // R4 pointer arming
    tok(0, 0, c, v);
    wr(3, 8'h12);
    rd("R4 hi no arm", 0, 3'b010);
    tok(1, 0, c, v); chk("R4 in nak", c, 2);
    wr(4, 8'h34);
    rd("R4 lo arm", 0, 3'b110);
    rd("R4 ptr hi", 3, 8'h12); rd("R4 ptr lo", 4, 8'h34);
    tok(1, 0, c, v); chk("R4 in data", c, 0);

    // R6 clearing events
    pulse_ack(0);
    rd("R6 busy clr", 0, 3'b010);
    tok(1, 0, c, v); chk("R6 in nak", c, 2);
    wr(2, 8'h40);
    rd("R5 out cnt", 2, 8'h40);
    tok(2, 0, c, v); chk("R6 out ack", c, 1);
    pulse_ack(1);
    tok(2, 0, c, v); chk("R6 out nak", c, 2);

    // R7 ignored writes
    wr(0, 8'h04);
    rd("R7 bit2 ro", 0, 3'b010);
    wr(0, 8'h00);
    rd("R7 w0 keep", 0, 3'b010);
    tok(2, 1, c, v); chk("R7 still nak", c, 2);
    wr(0, 8'h02);
    rd("R7 w1 clr", 0, 3'b000);
    tok(2, 1, c, v); chk("R8 ack", c, 1);
    wr(0, 8'h01); wr(1, 5);
    tok(1, 0, c, v); chk("R9 armed stall", c, 3);
    wr(0, 8'h00);
    rd("R9 clr", 0, 3'b100);

    // R2 setup wins over same-cycle write
    @(negedge clk); tok_setup = 1; cpu_we = 1; cpu_addr = 0; cpu_wdata = 8'h03;
    @(negedge clk); tok_setup = 0; cpu_we = 0;
    rd("R2 collide", 0, 3'b010);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule